// File: doc/BRIEF.md
# Crossbar Output Latch Stage

This block is the final stage of one output of a signal-routing crossbar. Any number of trip-source lines come in. A register-controlled enable mask picks which of them take part, and the picked lines are ORed into one signal. That signal passes through a chain of flip-flops so it is synchronous to the module clock, nominally 200 MHz.

The synchronized level feeds a sticky flag. Software can force the flag high or clear it. A latch-select bit decides what drives the output pin: either the live synchronized level or the sticky flag. A final polarity inversion is applied only at the pin.

Software uses a small word-addressed register port:

- **Address 0 (control):** bit 0 is latch-select and bit 1 is output-invert. Both are read/write.
- **Address 1 (enable mask):** one bit per source, read/write.
- **Address 2 (state, read-only):** bit 0 is the synchronized input level and bit 1 is the sticky flag.
- **Address 3 (command):** bit 0 clears the flag and bit 1 forces it. Both are write-1 pulses, and the register always reads back as 0.

Read data is combinational from the address.

Top module: `xbar_out_stage`

## Requirements
- R1: The combined input is the OR of every source whose bit is set in the enable mask (address 1). Sources with a cleared mask bit have no effect. A zero mask gives a constant 0.
- R2: A change on the combined input appears in the synchronized level after exactly two rising clock edges.
- R3: Status bit 0 of address 2 always equals the synchronized level. It does not depend on the flag, latch-select or invert.
- R4: The flag (address 2 bit 1) is set on any edge where the synchronized level is high. It stays set after that level returns low.
- R5: Writing 1 to address 3 bit 0 clears the flag at that edge. Address 3 always reads 0.
- R6: Writing 1 to address 3 bit 1 sets the flag at that edge, whatever the input is.
- R7: When a clear and a set condition (high synchronized level or force) meet on the same edge, the flag ends up set.
- R8: With latch-select (address 0 bit 0) at 0, the pin follows the synchronized level, and forcing the flag does not change the pin.
- R9: With latch-select at 1, the pin follows the flag. This includes a forced flag while the input is low.
- R10: Output-invert (address 0 bit 1) inverts only the pin. Status and flag readings keep their polarity.
- R11: After reset the flag, synchronized level, control bits and enable mask are all 0, and the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC | Trip-source lines, asynchronous to clk |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data for regAddr |
| pinOut | output | 1 | Crossbar output pin |

## Verification
A flag clear can land on the same edge as a set condition. The set condition is either a high synchronized level or a force written in the same command word. The bench provokes this in two ways. First, it holds an enabled source high and then writes clear. Second, it writes both command bits in a single write. In both cases it judges the flag reading and the latched pin on the following cycle against a behavioural model that gives the set priority.

// File: rtl/xbar_out_pkg.sv
package xbar_out_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STATE  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CMD    = 2'd3;

  // one-cycle software commands to the datapath
  typedef struct packed {
    logic flagClr;
    logic flagFrc;
  } flagStrobes_t;
endpackage

// File: rtl/xbar_out_ctrl.sv
module xbar_out_ctrl
  import xbar_out_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              syncLvl,
  input  logic              flagLvl,
  output flagStrobes_t      strobes,
  output logic [NUM_SRC-1:0] enMask,
  output logic              latchSel,
  output logic              invertOut
);
  logic unusedWr;
  assign unusedWr = ^regWrData[DATA_W-1:2];

  logic wrCtrl, wrEnable, wrCmd;
  assign wrCtrl   = regWrEn && (regAddr == ADDR_CTRL);
  assign wrEnable = regWrEn && (regAddr == ADDR_ENABLE);
  assign wrCmd    = regWrEn && (regAddr == ADDR_CMD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchSel  <= 1'b0;
      invertOut <= 1'b0;
      enMask    <= '0;
    end else begin
      if (wrCtrl) begin
        latchSel  <= regWrData[0];
        invertOut <= regWrData[1];
      end
      if (wrEnable) enMask <= regWrData[NUM_SRC-1:0];
    end
  end

  always_comb begin
    strobes.flagClr = wrCmd && regWrData[0];
    strobes.flagFrc = wrCmd && regWrData[1];
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL:   regRdData[1:0] = {invertOut, latchSel};
      ADDR_ENABLE: regRdData = DATA_W'(enMask);
      ADDR_STATE:  regRdData[1:0] = {flagLvl, syncLvl};
      default:     regRdData = '0;
    endcase
  end

  assert_cmd_reads_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_CMD) |-> (regRdData == '0));

  assert_ctrl_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> (latchSel == $past(regWrData[0])));
endmodule

// File: rtl/xbar_out_path.sv
module xbar_out_path
  import xbar_out_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SRC-1:0] enMask,
  input  flagStrobes_t       strobes,
  input  logic               latchSel,
  input  logic               invertOut,
  output logic               syncLvl,
  output logic               flagLvl,
  output logic               pinOut
);
  logic combined;
  assign combined = |(srcIn & enMask);

  logic [SYNC_STAGES-1:0] syncQ;
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       syncQ[g] <= 1'b0;
        else if (g == 0) syncQ[g] <= combined;
        else             syncQ[g] <= syncQ[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate
  assign syncLvl = syncQ[SYNC_STAGES-1];

  logic flagSet;
  assign flagSet = syncLvl || strobes.flagFrc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                flagLvl <= 1'b0;
    else if (flagSet)         flagLvl <= 1'b1;
    else if (strobes.flagClr) flagLvl <= 1'b0;
  end

  logic selected;
  assign selected = latchSel ? flagLvl : syncLvl;
  assign pinOut   = selected ^ invertOut;

  assert_flag_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    syncLvl |=> flagLvl);
  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flagLvl && !strobes.flagClr) |=> flagLvl);
  assert_force_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flagFrc |=> flagLvl);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.flagClr && (syncLvl || strobes.flagFrc)) |=> flagLvl);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.flagClr && !syncLvl && !strobes.flagFrc) |=> !flagLvl);

  generate
    if (SYNC_STAGES == 2) begin : gSyncCheck
      logic [1:0] agedQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              agedQ <= '0;
        else if (agedQ != 2'd2) agedQ <= agedQ + 2'd1;
      end
      assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
        (agedQ == 2'd2) |-> (syncLvl == $past(combined, 2)));
    end
  endgenerate
endmodule

// File: rtl/xbar_out_stage.sv
module xbar_out_stage
  import xbar_out_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               pinOut
);
  flagStrobes_t strobes;
  logic [NUM_SRC-1:0] enMask;
  logic latchSel, invertOut, syncLvl, flagLvl;

  xbar_out_ctrl #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .syncLvl(syncLvl),
    .flagLvl(flagLvl), .strobes(strobes), .enMask(enMask),
    .latchSel(latchSel), .invertOut(invertOut));

  xbar_out_path #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .enMask(enMask),
    .strobes(strobes), .latchSel(latchSel), .invertOut(invertOut),
    .syncLvl(syncLvl), .flagLvl(flagLvl), .pinOut(pinOut));

  assert_invert_pin_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!latchSel) |-> (pinOut == (syncLvl ^ invertOut)));
endmodule

// File: tb/xbar_out_stage_test.sv
`timescale 1ns/1ps
module xbar_out_stage_test;
  localparam int NSRC = 8;
  localparam int DW   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NSRC-1:0] srcIn = '0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic pinOut;

  always #2 clk = ~clk;

  xbar_out_stage #(.NUM_SRC(NSRC), .DATA_W(DW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .pinOut(pinOut));

  // behavioural reference model
  int nCmp = 0;
  int nBad = 0;
  string phase = "R11";
  bit mS1, mS2, mFlag, mSel, mInv;
  bit [NSRC-1:0] mEn;
  bit [NSRC-1:0] hist[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mFlag = 0; mSel = 0; mInv = 0; mEn = '0;
    end else begin
      bit frc, clr, comb;
      comb = |(srcIn & mEn);
      frc = regWrEn && regAddr == 2'd3 && regWrData[1];
      clr = regWrEn && regAddr == 2'd3 && regWrData[0];
      if (mS2 || frc) mFlag = 1;
      else if (clr)   mFlag = 0;
      mS2 = mS1;
      mS1 = comb;
      if (regWrEn && regAddr == 2'd0) begin mSel = regWrData[0]; mInv = regWrData[1]; end
      if (regWrEn && regAddr == 2'd1) mEn = regWrData[NSRC-1:0];
    end
  end

  task automatic compare();
    bit expPin;
    bit [DW-1:0] expRd;
    expPin = (mSel ? mFlag : mS2) ^ mInv;
    case (regAddr)
      2'd0: expRd = DW'({mInv, mSel});
      2'd1: expRd = DW'(mEn);
      2'd2: expRd = DW'({mFlag, mS2});
      default: expRd = '0;
    endcase
    nCmp++;
    if (pinOut !== expPin) begin
      nBad++;
      $display("FAIL %s pin: got %0b exp %0b", phase, pinOut, expPin);
    end
    nCmp++;
    if (regRdData !== expRd) begin
      nBad++;
      $display("FAIL %s rd[%0d]: got %h exp %h", phase, regAddr, regRdData, expRd);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0; regWrData = '0; regAddr = 2'd2;
  endtask

  task automatic peek(logic [1:0] a);
    regAddr = a;
    step();
    regAddr = 2'd2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11: reset state on every register and the pin
    phase = "R11";
    peek(2'd0); peek(2'd1); peek(2'd2); peek(2'd3);

    // R1: masked sources ignored, enabled source passes, empty mask gives 0
    phase = "R1";
    wr(2'd1, 16'h0005);
    srcIn = 8'hFA; step(4);
    srcIn = 8'h04; step(4);
    wr(2'd3, 16'h0001); step(1);
    wr(2'd1, 16'h0000); srcIn = 8'hFF; step(4);
    wr(2'd3, 16'h0001); step(2);

    // R2: one-cycle pulse travels through two stages
    phase = "R2";
    wr(2'd1, 16'h0001);
    srcIn = 8'h01; step(1); srcIn = 8'h00; step(4);

    // R4: flag remains after the input drops
    phase = "R4";
    peek(2'd2); step(3);

    // R5: clear, and command register reads zero
    phase = "R5";
    wr(2'd3, 16'h0001); step(2); peek(2'd3);

    // R6 / R8: force with input low, latch not selected
    phase = "R8";
    wr(2'd3, 16'h0002); step(3);
    wr(2'd3, 16'h0001); step(1);

    // R9: latch selected, forced flag drives pin
    phase = "R9";
    wr(2'd0, 16'h0001); step(2);
    wr(2'd3, 16'h0002); step(3);
    wr(2'd3, 16'h0001); step(2);

    // R7: clear meets a high level, then clear with force
    phase = "R7";
    srcIn = 8'h01; step(4);
    wr(2'd3, 16'h0001); step(1);
    srcIn = 8'h00; step(3);
    wr(2'd3, 16'h0003); step(2);
    wr(2'd3, 16'h0001); step(2);

    // R10 / R3: inversion only at the pin, status unchanged
    phase = "R10";
    wr(2'd0, 16'h0002); step(2);
    srcIn = 8'h01; step(4); peek(2'd0);
    phase = "R3";
    wr(2'd0, 16'h0003); srcIn = 8'h00; step(4);
    wr(2'd3, 16'h0001); step(3);
    srcIn = 8'h01; step(1); srcIn = 8'h00; step(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule